// File: doc/BRIEF.md
# Pin Interrupt Request Controller

This block turns eight general-purpose input pins into eight interrupt request lines. Each request line feeds a downstream controller that reacts to rising edges. Every channel is either edge-sensitive or level-sensitive. In edge mode the channel can catch rising edges, falling edges or both. Each detected edge is held until software acknowledges it. In level mode the request follows the pin for as long as the pin is at the chosen active level.

Software uses a small 32-bit register bus with select/enable/write strobes. Enables are never written directly. Dedicated set addresses and clear addresses change single bits atomically, so no read-modify-write is needed. In level mode the two enable vectors change meaning: the rising enable becomes the level enable, and the falling enable becomes the polarity select. Each pin passes through a two-stage synchronizer before any detection.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every readable register returns 0 and every request line is low.
- R2: Byte offset 0x08 sets and 0x0C clears bits of the rising/level enable. Offset 0x14 sets and 0x18 clears bits of the falling/polarity enable. A 1 in write data changes the bit and a 0 leaves it alone. Reads of 0x04, 0x08 and 0x0C return the rising/level enable. Reads of 0x10, 0x14 and 0x18 return the falling/polarity enable. Writes to 0x04 and 0x10 are ignored, and bits 31:8 always read 0.
- R3: Offset 0x00 is the mode register, read/write, with bit n for channel n. A 1 selects level mode and a 0 selects edge mode.
- R4: In edge mode a synchronized 0-to-1 change on a pin with its rising enable set sets bit n of the rise register (0x1C) and of the status register (0x24). The request line rises exactly three clock edges after the pin changes.
- R5: In edge mode a 1-to-0 change with its falling enable set sets bit n of the fall register (0x20) and of status. An edge whose enable is clear is not recorded.
- R6: A channel with both enables set in edge mode records both edge directions.
- R7: In edge mode, writing 1 to status bit n clears status, rise and fall bits n. Channels written with 0 keep their state.
- R8: In level mode, status bit n equals (level enable n) AND (synchronized pin n equals polarity n). Polarity 1 means active-high and 0 means active-low. The request line follows this value.
- R9: In level mode, writing the status register has no effect on that channel.
- R10: Request line n is high exactly when status bit n is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pin_i | input | N_CH | Asynchronous input pins |
| irq_o | output | N_CH | Interrupt request lines, one per channel |

## Verification
The edge function is driven with isolated rising pulses, isolated falling pulses and complete pulses. Each is run on channels with only the rising enable, only the falling enable, or both enabled. This separates the direction decode from the enable gating. Acknowledges that carry several ones and zeros at once show whether clearing is per channel. The level function is driven with the pin both matching and opposing each polarity, and then with the enable removed. This separates the polarity compare from the level enable and shows that acknowledge writes do not affect a level channel.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    localparam int unsigned CH_DEFAULT = 8;
    localparam logic [7:0] OFF_MODE = 8'h00;
    localparam logic [7:0] OFF_REN  = 8'h04;
    localparam logic [7:0] OFF_RSET = 8'h08;
    localparam logic [7:0] OFF_RCLR = 8'h0C;
    localparam logic [7:0] OFF_FEN  = 8'h10;
    localparam logic [7:0] OFF_FSET = 8'h14;
    localparam logic [7:0] OFF_FCLR = 8'h18;
    localparam logic [7:0] OFF_RDET = 8'h1C;
    localparam logic [7:0] OFF_FDET = 8'h20;
    localparam logic [7:0] OFF_STAT = 8'h24;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = s_i;
        rise_o = s_i & ~prev_q;
        fall_o = ~s_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int unsigned N_CH   = CH_DEFAULT,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [N_CH-1:0]   wdata_i,
    output logic [DATA_W-1:0] prdata,
    input  logic [N_CH-1:0]   pin_s_i,
    input  logic [N_CH-1:0]   rise_ev_i,
    input  logic [N_CH-1:0]   fall_ev_i,
    output logic [N_CH-1:0]   mode_o,
    output logic [N_CH-1:0]   ena_r_o,
    output logic [N_CH-1:0]   ena_f_o,
    output logic [N_CH-1:0]   rise_o,
    output logic [N_CH-1:0]   fall_o,
    output logic [N_CH-1:0]   stat_o
);
    typedef struct packed {
        logic [N_CH-1:0] mode;
        logic [N_CH-1:0] ena_r;
        logic [N_CH-1:0] ena_f;
        logic [N_CH-1:0] rise;
        logic [N_CH-1:0] fall;
        logic [N_CH-1:0] stat;
    } regs_t;

    regs_t r_d, r_q;
    logic [7:0]      addr8;
    logic            wr;
    logic [N_CH-1:0] ack, rise_set, fall_set, lvl;

    always_comb begin
        addr8    = 8'(paddr);
        wr       = psel & penable & pwrite;
        r_d      = r_q;
        ack      = '0;
        if (wr) begin
            case (addr8)
                OFF_MODE: r_d.mode  = wdata_i;
                OFF_RSET: r_d.ena_r = r_q.ena_r | wdata_i;
                OFF_RCLR: r_d.ena_r = r_q.ena_r & ~wdata_i;
                OFF_FSET: r_d.ena_f = r_q.ena_f | wdata_i;
                OFF_FCLR: r_d.ena_f = r_q.ena_f & ~wdata_i;
                OFF_STAT: ack       = wdata_i & ~r_q.mode;
                default: ;
            endcase
        end
        rise_set = rise_ev_i & r_q.ena_r & ~r_q.mode;
        fall_set = fall_ev_i & r_q.ena_f & ~r_q.mode;
        lvl      = r_q.ena_r & ~(pin_s_i ^ r_q.ena_f);
        r_d.rise = (r_q.rise & ~ack) | rise_set;
        r_d.fall = (r_q.fall & ~ack) | fall_set;
        r_d.stat = (r_q.mode & lvl)
                 | (~r_q.mode & ((r_q.stat & ~ack) | rise_set | fall_set));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        prdata = '0;
        case (addr8)
            OFF_MODE:                     prdata[N_CH-1:0] = r_q.mode;
            OFF_REN, OFF_RSET, OFF_RCLR:  prdata[N_CH-1:0] = r_q.ena_r;
            OFF_FEN, OFF_FSET, OFF_FCLR:  prdata[N_CH-1:0] = r_q.ena_f;
            OFF_RDET:                     prdata[N_CH-1:0] = r_q.rise;
            OFF_FDET:                     prdata[N_CH-1:0] = r_q.fall;
            OFF_STAT:                     prdata[N_CH-1:0] = r_q.stat;
            default: ;
        endcase
    end

    assign mode_o  = r_q.mode;
    assign ena_r_o = r_q.ena_r;
    assign ena_f_o = r_q.ena_f;
    assign rise_o  = r_q.rise;
    assign fall_o  = r_q.fall;
    assign stat_o  = r_q.stat;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int unsigned N_CH   = CH_DEFAULT,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [N_CH-1:0]   pin_i,
    output logic [N_CH-1:0]   irq_o
);
    logic [N_CH-1:0] pin_s_w, rise_ev_w, fall_ev_w;
    logic [N_CH-1:0] mode_w, ena_r_w, ena_f_w, rise_w, fall_w, stat_w;
    logic            unused_hi;

    assign unused_hi = ^pwdata[31:N_CH];

    pin_irq_sync #(.W(N_CH), .STAGES(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s_w)
    );

    pin_irq_edge #(.W(N_CH)) edge_i (
        .clk(clk), .rst_n(rst_n), .s_i(pin_s_w),
        .rise_o(rise_ev_w), .fall_o(fall_ev_w)
    );

    pin_irq_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(32)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .wdata_i(pwdata[N_CH-1:0]), .prdata(prdata),
        .pin_s_i(pin_s_w), .rise_ev_i(rise_ev_w), .fall_ev_i(fall_ev_w),
        .mode_o(mode_w), .ena_r_o(ena_r_w), .ena_f_o(ena_f_w),
        .rise_o(rise_w), .fall_o(fall_w), .stat_o(stat_w)
    );

    assign irq_o = stat_w;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
    import pin_irq_pkg::*;
#(
    parameter int unsigned N_CH   = CH_DEFAULT,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [N_CH-1:0]   pin_s_w,
    input logic [N_CH-1:0]   mode_w,
    input logic [N_CH-1:0]   ena_r_w,
    input logic [N_CH-1:0]   ena_f_w,
    input logic [N_CH-1:0]   rise_w,
    input logic [N_CH-1:0]   stat_w
);
    logic            acc;
    logic [N_CH-1:0] wd;
    assign acc = psel & penable & pwrite;
    assign wd  = pwdata[N_CH-1:0];

    p_set_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && 8'(paddr) == OFF_RSET) |=> ((ena_r_w & $past(wd)) == $past(wd)));

    p_clr_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && 8'(paddr) == OFF_FCLR) |=> ((ena_f_w & $past(wd)) == '0));

    p_rise_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_w & ~$past(rise_w) & ~$past(ena_r_w)) == '0));

    p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(mode_w) & (stat_w ^ ($past(ena_r_w)
                  & ~($past(pin_s_w) ^ $past(ena_f_w))))) == '0));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pin_s_w(pin_s_w),
    .mode_w(mode_w), .ena_r_w(ena_r_w), .ena_f_w(ena_f_w),
    .rise_w(rise_w), .stat_w(stat_w)
);

// File: tb/pin_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [7:0]  pins = '0;
    logic [7:0]  irq;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    pin_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pin_i(pins), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        for (int a = 0; a <= 'h24; a += 4) rd_chk("R1 reg", 6'(a), 0);
    endtask

    task automatic t_strobes();
        bus_wr(6'h08, 32'hFFFF_FF05);
        rd_chk("R2 set rise", 6'h04, 32'h05);
        bus_wr(6'h08, 32'h0);
        rd_chk("R2 zero set", 6'h08, 32'h05);
        bus_wr(6'h0C, 32'h04);
        rd_chk("R2 clr rise", 6'h0C, 32'h01);
        bus_wr(6'h04, 32'hFF);
        rd_chk("R2 ro rise", 6'h04, 32'h01);
        bus_wr(6'h14, 32'h30);
        bus_wr(6'h18, 32'h10);
        rd_chk("R2 fall", 6'h10, 32'h20);
        bus_wr(6'h10, 32'hFF);
        rd_chk("R2 ro fall", 6'h14, 32'h20);
        bus_wr(6'h0C, 32'hFF); bus_wr(6'h18, 32'hFF);
        rd_chk("R2 clr all", 6'h18, 32'h0);
        bus_wr(6'h00, 32'hFFFF_FFA5);
        rd_chk("R3 mode", 6'h00, 32'hA5);
        bus_wr(6'h00, 32'h0);
    endtask

    task automatic t_rise();
        bus_wr(6'h08, 32'h04);
        @(negedge clk); pins[2] = 1;
        repeat (2) @(negedge clk);
        chk("R4 latency early", 32'(irq[2]), 0);
        @(negedge clk);
        chk("R4 R10 irq rise", 32'(irq), 32'h04);
        rd_chk("R4 rise flag", 6'h1C, 32'h04);
        rd_chk("R4 status", 6'h24, 32'h04);
        pins[2] = 0; settle();
        rd_chk("R5 fall not enabled", 6'h20, 32'h0);
    endtask

    task automatic t_fall();
        bus_wr(6'h14, 32'h20);
        @(negedge clk); pins[5] = 1; settle();
        chk("R5 rise ignored", 32'(irq[5]), 0);
        pins[5] = 0; settle();
        chk("R5 irq fall", 32'(irq), 32'h24);
        rd_chk("R5 fall flag", 6'h20, 32'h20);
        rd_chk("R5 rise flag clean", 6'h1C, 32'h04);
    endtask

    task automatic t_ack();
        bus_wr(6'h24, 32'h04);
        @(negedge clk);
        chk("R7 partial ack irq", 32'(irq), 32'h20);
        rd_chk("R7 rise cleared", 6'h1C, 32'h0);
        rd_chk("R7 fall kept", 6'h20, 32'h20);
        bus_wr(6'h24, 32'hFF);
        rd_chk("R7 status clear", 6'h24, 32'h0);
        rd_chk("R7 fall cleared", 6'h20, 32'h0);
    endtask

    task automatic t_both();
        bus_wr(6'h08, 32'h01); bus_wr(6'h14, 32'h01);
        @(negedge clk); pins[0] = 1; settle();
        chk("R6 rise", 32'(irq[0]), 1);
        bus_wr(6'h24, 32'h01);
        chk("R6 ack", 32'(irq[0]), 0);
        pins[0] = 0; settle();
        chk("R6 fall", 32'(irq[0]), 1);
        rd_chk("R6 fall flag", 6'h20, 32'h01);
        bus_wr(6'h24, 32'hFF);
        bus_wr(6'h0C, 32'hFF); bus_wr(6'h18, 32'hFF);
    endtask

    task automatic t_level();
        bus_wr(6'h00, 32'h80);
        bus_wr(6'h08, 32'h80);
        settle();
        chk("R8 active low match", 32'(irq), 32'h80);
        pins[7] = 1; settle();
        chk("R8 active low idle", 32'(irq[7]), 0);
        bus_wr(6'h14, 32'h80); settle();
        chk("R8 active high match", 32'(irq[7]), 1);
        bus_wr(6'h24, 32'h80); settle();
        chk("R9 ack ignored", 32'(irq[7]), 1);
        rd_chk("R9 status", 6'h24, 32'h80);
        bus_wr(6'h0C, 32'h80); settle();
        chk("R8 level disabled", 32'(irq[7]), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_strobes();
        t_rise();
        t_fall();
        t_ack();
        t_both();
        t_level();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule